// File: doc/BRIEF.md
# DMA-fed playback frame buffer

This block sits between a DMA channel and an audio sink and holds stereo playback frames in a linear store. A frame is one 32-bit word that carries two 16-bit channel samples. The DMA side offers a transfer as a start address and a length in bytes. The block copies as many frames as still fit above its write pointer. It fetches one word per cycle through a simple fetch port whose data comes back in the same cycle. Whatever does not fit stays pending inside the block. The block pulses a completion strobe to the DMA channel only once the whole length has been taken.

The sink asks for up to N frames. It receives the frames that lie between the read and write pointers, one per cycle, under a valid/ready handshake, and a running frame counter advances with each frame handed over. The store does not wrap. When the read pointer catches up with the write pointer, both pointers return to zero. If a remainder is pending, the block fetches it straight away and then pulses a kick strobe, so the DMA channel continues with its run state untouched.

Control is one state machine with four states:
- IDLE waits for requests. The transition "accept" moves it to FILL when a DMA request brings at least one frame that fits. The transition "serve" moves it to PLAY when a sink request finds frames to deliver.
- FILL copies frames. The transition "filled" returns it to IDLE after its last frame.
- PLAY streams frames to the sink. The transition "burst end" returns it to IDLE when frames remain stored. The transition "drain" moves it to REWIND when the last stored frame has gone.
- REWIND clears both pointers. The transition "resume" moves it to FILL when a remainder is pending; otherwise the transition "rest" returns it to IDLE.

Top module: `pb_buffer`

## Requirements
- R1: Each fetched word is one frame. The fetch address starts at the request address and rises by 4 per frame. The sink receives the words in fetch order, across transfers and resumes alike.
- R2: An accepted DMA request takes min(floor(len/4), CAP − write pointer) frames, and the two low bits of the length are ignored. The write pointer never exceeds CAP.
- R3: dma_done pulses for one cycle only when the remaining length reaches zero, and dma_ready is high in that cycle. If frames are left over, no pulse is given and dma_ready stays low.
- R4: A sink request with a count of zero, or made while the buffer is empty, delivers no frame and leaves frame_cnt unchanged.
- R5: An accepted sink request delivers exactly min(count, write pointer − read pointer) frames. frame_cnt rises by one for each delivered frame.
- R6: While snk_valid is high and snk_ready is low, snk_valid stays high and snk_data stays stable.
- R7: When the last stored frame is delivered, both pointers return to zero, so a following transfer can again use the full capacity CAP.
- R8: On a full drain with a remainder pending, the block fetches min(remaining frames, CAP) frames at once, continuing from the address where it stopped. It then pulses dma_kick for one cycle, and also pulses dma_done if nothing remains.
- R9: While a remainder is pending, dma_ready is low and a held dma_req has no effect.
- R10: After reset, dma_ready is 1, and snk_valid, dma_done, dma_kick, fetch_en and frame_cnt are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_req | input | 1 | DMA transfer offer, held until dma_ready |
| dma_addr | input | AW | Start byte address of the offered transfer |
| dma_len | input | LW | Length of the offered transfer in bytes |
| dma_ready | output | 1 | Block is idle with nothing pending and accepts an offer |
| dma_done | output | 1 | One-cycle pulse: whole transfer taken |
| dma_kick | output | 1 | One-cycle pulse: deferred remainder fetched, channel may continue |
| fetch_en | output | 1 | Fetch one frame word this cycle |
| fetch_addr | output | AW | Byte address of the word being fetched |
| fetch_word | input | DW | Word returned for fetch_addr in the same cycle |
| snk_req | input | 1 | Sink asks for frames, held until snk_req_ready |
| snk_count | input | RQW | Number of frames the sink asks for |
| snk_req_ready | output | 1 | A sink request is taken this cycle |
| snk_valid | output | 1 | snk_data holds a frame |
| snk_ready | input | 1 | Sink takes the frame on snk_data |
| snk_data | output | DW | Frame delivered to the sink |
| frame_cnt | output | CW | Running count of delivered frames |

## Verification
The hardest situation to reach is a resume that starts from a partly used store. This needs a transfer to be split because the write pointer is not zero, and then a drain whose final burst ends exactly on the write pointer. The stimulus reaches it in several steps. It first drains a burst partly, so the pointers sit at a non-zero offset. It then offers a transfer that is larger than the remaining room, and pulls with a count that is larger than the stored frames, under alternating backpressure. The scoreboard holds every frame word by its address, so a resume that starts at the wrong address shows up as a data mismatch. So does an accepted refused offer, or a lost or duplicated frame.

// File: rtl/pb_pkg.sv
package pb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_PLAY,
        ST_REWIND
    } pb_state_e;
endpackage

// File: rtl/pb_store.sv
module pb_store #(
    parameter int CAP = 16,
    parameter int DW  = 32,
    localparam int IW = (CAP > 1) ? $clog2(CAP) : 1
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [CAP];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/pb_fsm.sv
module pb_fsm
    import pb_pkg::*;
#(
    parameter int CAP = 16,
    parameter int AW  = 32,
    parameter int LW  = 16,
    parameter int RQW = 8,
    parameter int CW  = 32,
    localparam int PW = $clog2(CAP + 1),
    localparam int IW = (CAP > 1) ? $clog2(CAP) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           dma_req,
    input  logic [AW-1:0]  dma_addr,
    input  logic [LW-1:0]  dma_len,
    output logic           dma_ready,
    output logic           dma_done,
    output logic           dma_kick,
    output logic           fetch_en,
    output logic [AW-1:0]  fetch_addr,
    input  logic           snk_req,
    input  logic [RQW-1:0] snk_count,
    output logic           snk_req_ready,
    output logic           snk_valid,
    input  logic           snk_ready,
    output logic [CW-1:0]  frame_cnt,
    output logic           wr_en,
    output logic [IW-1:0]  wr_idx,
    output logic [IW-1:0]  rd_idx
);
    pb_state_e      state, state_nx;
    logic [PW-1:0]  wp, rp, cnt, burst;
    logic [AW-1:0]  addr_q;
    logic [LW-1:0]  rem_q;
    logic           pending, resume;
    logic           done_q, kick_q;
    logic [CW-1:0]  frame_q;

    logic [LW-1:0]  len_frames, room, take_new, rem_frames, take_res;
    logic [PW-1:0]  avail;
    logic [RQW-1:0] avail_r, burst_n;
    logic           dma_go, snk_go, serve_ok;

    assign len_frames = {2'b00, dma_len[LW-1:2]};
    assign room       = LW'(CAP) - LW'(wp);
    assign take_new   = (len_frames < room) ? len_frames : room;
    assign rem_frames = {2'b00, rem_q[LW-1:2]};
    assign take_res   = (rem_frames < LW'(CAP)) ? rem_frames : LW'(CAP);
    assign avail      = wp - rp;
    assign avail_r    = RQW'(avail);
    assign burst_n    = (snk_count < avail_r) ? snk_count : avail_r;

    assign dma_go   = (state == ST_IDLE) && !pending && dma_req;
    assign snk_go   = (state == ST_IDLE) && !(dma_req && !pending) && snk_req;
    assign serve_ok = (snk_count != '0) && (avail != '0);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (dma_go) begin
                    if (take_new != '0) state_nx = ST_FILL;
                end else if (snk_go && serve_ok) begin
                    state_nx = ST_PLAY;
                end
            end
            ST_FILL: begin
                if (cnt == PW'(1)) state_nx = ST_IDLE;
            end
            ST_PLAY: begin
                if (snk_ready && burst == PW'(1))
                    state_nx = (rp + PW'(1) == wp) ? ST_REWIND : ST_IDLE;
            end
            ST_REWIND: begin
                state_nx = pending ? ST_FILL : ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp      <= '0;
            rp      <= '0;
            cnt     <= '0;
            burst   <= '0;
            addr_q  <= '0;
            rem_q   <= '0;
            pending <= 1'b0;
            resume  <= 1'b0;
            done_q  <= 1'b0;
            kick_q  <= 1'b0;
            frame_q <= '0;
        end else begin
            done_q <= 1'b0;
            kick_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (dma_go) begin
                        addr_q <= dma_addr;
                        rem_q  <= {dma_len[LW-1:2], 2'b00};
                        cnt    <= PW'(take_new);
                        if (take_new == '0) begin
                            if (len_frames == '0) done_q  <= 1'b1;
                            else                  pending <= 1'b1;
                        end
                    end else if (snk_go && serve_ok) begin
                        burst <= PW'(burst_n);
                    end
                end
                ST_FILL: begin
                    wp     <= wp + PW'(1);
                    addr_q <= addr_q + AW'(4);
                    rem_q  <= rem_q - LW'(4);
                    cnt    <= cnt - PW'(1);
                    if (cnt == PW'(1)) begin
                        if (rem_q == LW'(4)) begin
                            done_q  <= 1'b1;
                            pending <= 1'b0;
                        end else begin
                            pending <= 1'b1;
                        end
                        if (resume) kick_q <= 1'b1;
                        resume <= 1'b0;
                    end
                end
                ST_PLAY: begin
                    if (snk_ready) begin
                        rp      <= rp + PW'(1);
                        frame_q <= frame_q + CW'(1);
                        burst   <= burst - PW'(1);
                    end
                end
                ST_REWIND: begin
                    wp <= '0;
                    rp <= '0;
                    if (pending) begin
                        cnt    <= PW'(take_res);
                        resume <= 1'b1;
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        dma_ready     = (state == ST_IDLE) && !pending;
        snk_req_ready = (state == ST_IDLE) && !(dma_req && !pending);
        fetch_en      = (state == ST_FILL);
        wr_en         = (state == ST_FILL);
        snk_valid     = (state == ST_PLAY);
        fetch_addr    = addr_q;
        wr_idx        = wp[IW-1:0];
        rd_idx        = rp[IW-1:0];
        dma_done      = done_q;
        dma_kick      = kick_q;
        frame_cnt     = frame_q;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) wp <= PW'(CAP)); // R2
    AST_RD_BEHIND_WR: assert property (@(posedge clk) disable iff (!rst_n) rp <= wp); // R5
    AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (snk_valid && snk_ready) |=> frame_q == $past(frame_q) + CW'(1)); // R5
    AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        dma_done |-> dma_ready); // R3
    AST_PEND_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && pending && dma_req) |=> (rem_q == $past(rem_q) && wp == $past(wp))); // R9
    AST_KICK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        dma_kick |-> (state == ST_IDLE && !resume)); // R8
endmodule

// File: rtl/pb_buffer.sv
module pb_buffer #(
    parameter int CAP = 16,
    parameter int AW  = 32,
    parameter int LW  = 16,
    parameter int RQW = 8,
    parameter int CW  = 32,
    parameter int DW  = 32,
    localparam int IW = (CAP > 1) ? $clog2(CAP) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           dma_req,
    input  logic [AW-1:0]  dma_addr,
    input  logic [LW-1:0]  dma_len,
    output logic           dma_ready,
    output logic           dma_done,
    output logic           dma_kick,
    output logic           fetch_en,
    output logic [AW-1:0]  fetch_addr,
    input  logic [DW-1:0]  fetch_word,
    input  logic           snk_req,
    input  logic [RQW-1:0] snk_count,
    output logic           snk_req_ready,
    output logic           snk_valid,
    input  logic           snk_ready,
    output logic [DW-1:0]  snk_data,
    output logic [CW-1:0]  frame_cnt
);
    logic          wr_en;
    logic [IW-1:0] wr_idx, rd_idx;

    pb_fsm #(.CAP(CAP), .AW(AW), .LW(LW), .RQW(RQW), .CW(CW)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .dma_req       (dma_req),
        .dma_addr      (dma_addr),
        .dma_len       (dma_len),
        .dma_ready     (dma_ready),
        .dma_done      (dma_done),
        .dma_kick      (dma_kick),
        .fetch_en      (fetch_en),
        .fetch_addr    (fetch_addr),
        .snk_req       (snk_req),
        .snk_count     (snk_count),
        .snk_req_ready (snk_req_ready),
        .snk_valid     (snk_valid),
        .snk_ready     (snk_ready),
        .frame_cnt     (frame_cnt),
        .wr_en         (wr_en),
        .wr_idx        (wr_idx),
        .rd_idx        (rd_idx)
    );

    pb_store #(.CAP(CAP), .DW(DW)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (fetch_word),
        .rd_idx  (rd_idx),
        .rd_data (snk_data)
    );

    AST_HOLD_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (snk_valid && !snk_ready) |=> (snk_valid && $stable(snk_data))); // R6
    AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && $past(fetch_en)) |-> fetch_addr == $past(fetch_addr) + AW'(4)); // R1
endmodule

// File: tb/tb_pb_buffer.sv
`timescale 1ns/1ps
module tb_pb_buffer;
    localparam int CAP = 16;
    localparam int AW  = 32;
    localparam int LW  = 16;
    localparam int RQW = 8;
    localparam int CW  = 32;
    localparam int DW  = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           dma_req = 1'b0;
    logic [AW-1:0]  dma_addr = '0;
    logic [LW-1:0]  dma_len = '0;
    logic           dma_ready, dma_done, dma_kick, fetch_en;
    logic [AW-1:0]  fetch_addr;
    logic [DW-1:0]  fetch_word;
    logic           snk_req = 1'b0;
    logic [RQW-1:0] snk_count = '0;
    logic           snk_req_ready, snk_valid;
    logic           snk_ready = 1'b1;
    logic [DW-1:0]  snk_data;
    logic [CW-1:0]  frame_cnt;

    always #2.5 clk = ~clk;

    function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
        return {~a[15:0], a[15:0]};
    endfunction

    assign fetch_word = word_of(fetch_addr);

    pb_buffer #(.CAP(CAP), .AW(AW), .LW(LW), .RQW(RQW), .CW(CW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .dma_req(dma_req), .dma_addr(dma_addr), .dma_len(dma_len),
        .dma_ready(dma_ready), .dma_done(dma_done), .dma_kick(dma_kick),
        .fetch_en(fetch_en), .fetch_addr(fetch_addr), .fetch_word(fetch_word),
        .snk_req(snk_req), .snk_count(snk_count), .snk_req_ready(snk_req_ready),
        .snk_valid(snk_valid), .snk_ready(snk_ready), .snk_data(snk_data),
        .frame_cnt(frame_cnt)
    );

    int checks = 0, fails = 0;
    int sb_checks = 0, sb_fails = 0;
    int delivered = 0, done_seen = 0, kick_seen = 0;
    logic [DW-1:0] sbq [$];
    bit bp = 1'b0;

    // requirement model
    int mwp = 0, mrp = 0, mpend = 0, exp_done = 0, exp_kick = 0, exp_frames = 0;

    // backpressure driver: changes just after each rising edge
    always @(posedge clk) begin
        #1;
        snk_ready = bp ? ~snk_ready : 1'b1;
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (dma_done) done_seen++;
            if (dma_kick) kick_seen++;
            if (snk_valid && snk_ready) begin
                delivered++;
                sb_checks++;
                if (sbq.size() == 0) begin
                    sb_fails++;
                    $display("FAIL R5 extra frame: act=%h exp=none", snk_data);
                end else begin
                    logic [DW-1:0] e;
                    e = sbq.pop_front();
                    if (snk_data !== e) begin
                        sb_fails++;
                        $display("FAIL R1 frame data: act=%h exp=%h", snk_data, e);
                    end
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_rewind();
        if (mrp == mwp) begin
            mrp = 0; mwp = 0;
            if (mpend > 0) begin
                int t;
                t = (mpend < CAP) ? mpend : CAP;
                mwp = t;
                mpend -= t;
                exp_kick++;
                if (mpend == 0) exp_done++;
            end
        end
    endtask

    task automatic dma_send(input logic [AW-1:0] a, input int len);
        int f, t;
        f = len / 4;
        for (int i = 0; i < f; i++) sbq.push_back(word_of(a + AW'(4 * i)));
        t = (f < CAP - mwp) ? f : CAP - mwp;
        mwp += t;
        mpend = f - t;
        if (mpend == 0) exp_done++;
        @(negedge clk);
        dma_req = 1'b1; dma_addr = a; dma_len = LW'(len);
        #1;
        while (!dma_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        dma_req = 1'b0;
        settle(30);
    endtask

    task automatic dma_refused(input logic [AW-1:0] a, input int len);
        bit all_low = 1'b1;
        @(negedge clk);
        dma_req = 1'b1; dma_addr = a; dma_len = LW'(len);
        for (int i = 0; i < 10; i++) begin
            #1;
            if (dma_ready) all_low = 1'b0;
            @(negedge clk);
        end
        dma_req = 1'b0;
        check(all_low, "R9 dma_ready low while pending", all_low, 1);
        settle(5);
    endtask

    task automatic snk_pull(input int c, input string tag);
        int n, d0;
        n = 0;
        if (c != 0 && mwp != mrp) begin
            n = (c < mwp - mrp) ? c : mwp - mrp;
            mrp += n;
            model_rewind();
        end
        exp_frames += n;
        d0 = delivered;
        @(negedge clk);
        snk_req = 1'b1; snk_count = RQW'(c);
        #1;
        while (!snk_req_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        snk_req = 1'b0;
        settle(90);
        check(delivered - d0 == n, {tag, " frames delivered"}, delivered - d0, n);
        check(frame_cnt == CW'(exp_frames), {tag, " frame_cnt"}, frame_cnt, exp_frames);
    endtask

    task automatic check_strobes(input string tag);
        check(done_seen == exp_done, {tag, " dma_done pulses"}, done_seen, exp_done);
        check(kick_seen == exp_kick, {tag, " dma_kick pulses"}, kick_seen, exp_kick);
        check(dma_ready == (mpend == 0), {tag, " dma_ready"}, dma_ready, mpend == 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(dma_ready == 1'b1, "R10 dma_ready", dma_ready, 1);
        check(snk_valid == 1'b0 && fetch_en == 1'b0, "R10 valid/fetch idle", {snk_valid, fetch_en}, 0);
        check(dma_done == 1'b0 && dma_kick == 1'b0, "R10 strobes low", {dma_done, dma_kick}, 0);
        check(frame_cnt == '0, "R10 frame_cnt", frame_cnt, 0);
        rst_n = 1'b1;
        settle(2);

        // R2 R3: 8 frames fit completely
        dma_send(32'h0000_1000, 32);
        check_strobes("R3 full accept");
        // R5: partial pull
        snk_pull(3, "R5 pull 3");
        // R4: zero count ignored
        snk_pull(0, "R4 zero count");
        // R5 R7: pull more than stored, drains and rewinds
        snk_pull(10, "R5 pull clipped");
        // R4: empty buffer
        snk_pull(4, "R4 empty buffer");

        // R2 R3: 20 frames (83 bytes, low bits ignored), 16 accepted, 4 pending
        dma_send(32'h0000_2000, 83);
        check_strobes("R3 split transfer");
        // R9: refused while pending
        dma_refused(32'h0000_3000, 16);
        // R8 R6: drain under backpressure, remainder resumes
        bp = 1'b1;
        snk_pull(16, "R8 drain and resume");
        bp = 1'b0;
        check_strobes("R8 resume strobes");

        // R2: split from a non-zero write pointer
        snk_pull(2, "R5 pull 2");
        dma_send(32'h0000_4000, 56);
        check_strobes("R2 split at offset");
        bp = 1'b1;
        snk_pull(100, "R8 oversize pull");
        bp = 1'b0;
        check_strobes("R8 second resume");

        // R7: after drain the full capacity is usable again
        snk_pull(2, "R7 final drain");
        dma_send(32'h0000_5000, 4 * CAP);
        check_strobes("R7 full capacity");
        snk_pull(CAP, "R7 pull capacity");

        check(sbq.size() == 0, "R1 all frames delivered", sbq.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures",
                 checks + sb_checks, fails + sb_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        $display("FAIL watchdog: act=timeout exp=finish");
        $display("End of test - %0d assertions evaluated, %0d failures",
                 checks + sb_checks + 1, fails + sb_fails + 1);
        $finish;
    end
endmodule